// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This block is the execution stage for the bit-field operations of a 64-bit integer pipeline. Each cycle it takes an instruction word, the value of the source register, the current value of the destination register, and a flag that says whether 64-bit operations are allowed. From these it computes the value to write back to the destination register. It also raises a write-enable or a reserved-instruction indication. The register file, the rest of the pipeline and exception delivery are outside the block.

The block handles two kinds of operation:
- **Extract** pulls a contiguous field out of the source and right-aligns it.
- **Insert** replaces a contiguous field of the destination with the low bits of the source.

Both kinds come in a 32-bit form and in 64-bit forms. The 64-bit fields are reached through three split encodings, because the instruction holds two 5-bit position fields and each can be biased by 32. The decode and field logic is purely combinational. The results are captured in a single output register, so the outputs reflect the inputs presented at the previous clock edge.

Top module: `bfx_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the outputs become zero after that edge: `result_o`, `wr_en_o` and `resv_o`.
- R2: Function code 000000 is the 32-bit extract. The source's bits [31:0] are taken, with the bits above 31 treated as zero. The field from bit `lsb` up to bit `lsb+size` is right-aligned and zero-filled. The result is then sign-extended from bit 31 to 64 bits.
- R3: Function code 000011 is the 64-bit extract. The result is source bits [lsb+size : lsb], zero-extended. Any field position above bit 63 reads as zero.
- R4: Function code 000001 is the middle extract. The field is source bits [lsb+size+32 : lsb], zero-extended, so its width is size+33.
- R5: Function code 000010 is the upper extract. The field is source bits [lsb+32+size : lsb+32], zero-extended.
- R6: Function code 000100 is the 32-bit insert. Target bits [msb:lsb] are replaced by the low bits of the source, shifted left by `lsb`. The other target bits are kept, and the low 32 bits are sign-extended from bit 31.
- R7: Function code 000111 is the 64-bit insert. Target bits [msb:lsb] are replaced by the source shifted left by `lsb`. The other 64 target bits are kept.
- R8: Function code 000101 is the insert with the top bit moved up by 32. Target bits [msb+32 : lsb] are replaced by the source shifted left by `lsb`.
- R9: Function code 000110 is the insert with both bounds moved up by 32. Target bits [msb+32 : lsb+32] are replaced by the source shifted left by `lsb+32`.
- R10: An insert whose low bound exceeds its effective high bound returns the full 64-bit target value unchanged, with `wr_en_o` high. This holds for the 32-bit form too, without sign extension.
- R11: Any of the six 64-bit function codes presented with `en64_i` low gives `resv_o` high and `wr_en_o` low.
- R12: Fields are read from these instruction bits:

  | Field | Bits |
  |---|---|
  | major opcode | [31:26] |
  | size/msb | [15:11] |
  | lsb | [10:6] |
  | function code | [5:0] |

  A major opcode of 011111 selects this block. If the function code is not one of the eight listed, `resv_o` is high and `wr_en_o` is low. If the major opcode is anything other than 011111, both are low. `wr_en_o` and `resv_o` are never high together.
- R13: The outputs change only at a rising clock edge. They reflect the inputs sampled at that edge, which is a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 64 | Source register value |
| rt_val_i | input | 64 | Current destination register value |
| en64_i | input | 1 | 64-bit operations permitted |
| result_o | output | 64 | Value to write back |
| wr_en_o | output | 1 | Write back the result |
| resv_o | output | 1 | Reserved-instruction condition |

## Verification
The bench targets four groups of corner cases.
- **Extract fields that run off the top of the word.** Examples are an upper extract with both fields at 31, and a middle extract at full width. A design that wraps the shift or builds its mask too narrow would leak low source bits into the high result.
- **Empty insert ranges in each insert form.** A design that still merges would corrupt the target. One that sign-extends the 32-bit form would alter the upper half.
- **32-bit extracts whose field crosses bit 31.** These catch a design that pulls in source bits above 31, or that skips the sign extension.
- **Gating by the 64-bit permission flag, unknown function codes and foreign major opcodes.** A wrong design would write back when it should trap, or trap when it should stay silent.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;
    localparam int FLD_W  = 5;
    localparam int POS_W  = $clog2(DATA_W) + 1;
    localparam int OPC_W  = 6;

    localparam logic [OPC_W-1:0] MAJOR_BF    = 6'b011111;
    localparam logic [OPC_W-1:0] FN_EXT_N    = 6'b000000;
    localparam logic [OPC_W-1:0] FN_INS_N    = 6'b000100;
    localparam logic [OPC_W-1:0] FN_EXT_W    = 6'b000011;
    localparam logic [OPC_W-1:0] FN_EXT_MID  = 6'b000001;
    localparam logic [OPC_W-1:0] FN_EXT_UP   = 6'b000010;
    localparam logic [OPC_W-1:0] FN_INS_W    = 6'b000111;
    localparam logic [OPC_W-1:0] FN_INS_MID  = 6'b000101;
    localparam logic [OPC_W-1:0] FN_INS_UP   = 6'b000110;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_EXT  = 2'd1,
        OP_INS  = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e         kind;
        logic             narrow;
        logic             wide;
        logic [POS_W-1:0] lo;
        logic [POS_W-1:0] hi;
        logic             illegal;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              wr_en;
        logic              resv;
    } out_t;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
    import bfx_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic        en64_i,
    output dec_t        dec_o
);
    localparam logic [POS_W-1:0] BIAS = POS_W'(HALF_W);

    logic [POS_W-1:0] fld_a;
    logic [POS_W-1:0] fld_l;
    logic             unused_sel;

    assign fld_a      = POS_W'(instr_i[15:11]);
    assign fld_l      = POS_W'(instr_i[10:6]);
    assign unused_sel = ^instr_i[25:16];

    always_comb begin
        dec_o      = '0;
        dec_o.kind = OP_NONE;
        if (instr_i[31:26] == MAJOR_BF) begin
            unique case (instr_i[5:0])
                FN_EXT_N: begin
                    dec_o.kind   = OP_EXT;
                    dec_o.narrow = 1'b1;
                    dec_o.lo     = fld_l;
                    dec_o.hi     = fld_l + fld_a;
                end
                FN_EXT_W: begin
                    dec_o.kind = OP_EXT;
                    dec_o.wide = 1'b1;
                    dec_o.lo   = fld_l;
                    dec_o.hi   = fld_l + fld_a;
                end
                FN_EXT_MID: begin
                    dec_o.kind = OP_EXT;
                    dec_o.wide = 1'b1;
                    dec_o.lo   = fld_l;
                    dec_o.hi   = fld_l + fld_a + BIAS;
                end
                FN_EXT_UP: begin
                    dec_o.kind = OP_EXT;
                    dec_o.wide = 1'b1;
                    dec_o.lo   = fld_l + BIAS;
                    dec_o.hi   = fld_l + fld_a + BIAS;
                end
                FN_INS_N: begin
                    dec_o.kind   = OP_INS;
                    dec_o.narrow = 1'b1;
                    dec_o.lo     = fld_l;
                    dec_o.hi     = fld_a;
                end
                FN_INS_W: begin
                    dec_o.kind = OP_INS;
                    dec_o.wide = 1'b1;
                    dec_o.lo   = fld_l;
                    dec_o.hi   = fld_a;
                end
                FN_INS_MID: begin
                    dec_o.kind = OP_INS;
                    dec_o.wide = 1'b1;
                    dec_o.lo   = fld_l;
                    dec_o.hi   = fld_a + BIAS;
                end
                FN_INS_UP: begin
                    dec_o.kind = OP_INS;
                    dec_o.wide = 1'b1;
                    dec_o.lo   = fld_l + BIAS;
                    dec_o.hi   = fld_a + BIAS;
                end
                default: begin
                    dec_o.illegal = 1'b1;
                end
            endcase
            if (dec_o.wide && !en64_i) begin
                dec_o.kind    = OP_NONE;
                dec_o.illegal = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath
    import bfx_pkg::*;
(
    input  op_kind_e          kind_i,
    input  logic              narrow_i,
    input  logic [POS_W-1:0]  lo_i,
    input  logic [POS_W-1:0]  hi_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] tgt_i,
    output logic [DATA_W-1:0] res_o
);
    logic [DATA_W-1:0] src_eff;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] placed;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] ins_mask;
    logic [DATA_W-1:0] raw;
    logic [POS_W-1:0]  span;
    logic              empty;

    assign src_eff = narrow_i ? {{HALF_W{1'b0}}, src_i[HALF_W-1:0]} : src_i;
    assign shifted = (lo_i >= POS_W'(DATA_W)) ? '0 : (src_eff >> lo_i);
    assign placed  = (lo_i >= POS_W'(DATA_W)) ? '0 : (src_i << lo_i);
    assign span    = hi_i - lo_i;
    assign empty   = lo_i > hi_i;

    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        assign keep_mask[b] = (POS_W'(b) <= span);
        assign ins_mask[b]  = (POS_W'(b) >= lo_i) && (POS_W'(b) <= hi_i);
    end

    always_comb begin
        unique case (kind_i)
            OP_EXT:  raw = shifted & keep_mask;
            OP_INS:  raw = (tgt_i & ~ins_mask) | (placed & ins_mask);
            default: raw = '0;
        endcase
        if (kind_i == OP_INS && empty) begin
            res_o = tgt_i;
        end else if (narrow_i) begin
            res_o = {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
        end else begin
            res_o = raw;
        end
    end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr_i,
    input  logic [DATA_W-1:0] rs_val_i,
    input  logic [DATA_W-1:0] rt_val_i,
    input  logic              en64_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic              resv_o
);
    dec_t              dec;
    logic [DATA_W-1:0] dp_res;
    out_t              st_d;
    out_t              st_q;

    bfx_decode u_dec (
        .instr_i (instr_i),
        .en64_i  (en64_i),
        .dec_o   (dec)
    );

    bfx_datapath u_dp (
        .kind_i   (dec.kind),
        .narrow_i (dec.narrow),
        .lo_i     (dec.lo),
        .hi_i     (dec.hi),
        .src_i    (rs_val_i),
        .tgt_i    (rt_val_i),
        .res_o    (dp_res)
    );

    always_comb begin
        st_d        = '0;
        st_d.wr_en  = (dec.kind != OP_NONE);
        st_d.resv   = dec.illegal;
        st_d.result = st_d.wr_en ? dp_res : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign wr_en_o  = st_q.wr_en;
    assign resv_o   = st_q.resv;
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk
    import bfx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       instr_i,
    input logic [DATA_W-1:0] rt_val_i,
    input logic              en64_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic              resv_o
);
    logic major;
    logic wide_fn;
    logic unused_chk;

    assign major      = (instr_i[31:26] == MAJOR_BF);
    assign wide_fn    = (instr_i[5:0] == FN_EXT_W)  || (instr_i[5:0] == FN_EXT_MID) ||
                        (instr_i[5:0] == FN_EXT_UP) || (instr_i[5:0] == FN_INS_W)   ||
                        (instr_i[5:0] == FN_INS_MID)|| (instr_i[5:0] == FN_INS_UP);
    assign unused_chk = ^instr_i[25:16];

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !wr_en_o && !resv_o));

    assert_narrow_sext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (major && instr_i[5:0] == FN_EXT_N) |=> (result_o[DATA_W-1:HALF_W] == {HALF_W{result_o[HALF_W-1]}}));

    assert_empty_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (major && en64_i && instr_i[5:0] == FN_INS_W && instr_i[10:6] > instr_i[15:11])
        |=> (wr_en_o && result_o == $past(rt_val_i)));

    assert_gate_wide_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (major && wide_fn && !en64_i) |=> (resv_o && !wr_en_o));

    assert_foreign_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !major |=> (!wr_en_o && !resv_o));

    assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && resv_o));
endmodule

bind bfx_unit bfx_unit_chk u_chk (.*);

// File: tb/bfx_unit_test.sv
module bfx_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic [63:0] rs_val_i = '0;
    logic [63:0] rt_val_i = '0;
    logic        en64_i = 1'b1;
    logic [63:0] result_o;
    logic        wr_en_o;
    logic        resv_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5ns clk = ~clk;

    bfx_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr_i  (instr_i),
        .rs_val_i (rs_val_i),
        .rt_val_i (rt_val_i),
        .en64_i   (en64_i),
        .result_o (result_o),
        .wr_en_o  (wr_en_o),
        .resv_o   (resv_o)
    );

    function automatic logic [31:0] mk(input logic [5:0] fn, input int a, input int l);
        return {6'b011111, 5'd3, 5'd7, a[4:0], l[4:0], fn};
    endfunction

    function automatic string req_tag(input logic [31:0] ins, input logic en);
        int a = int'(ins[15:11]);
        int l = int'(ins[10:6]);
        if (ins[31:26] != 6'b011111) return "R12";
        case (ins[5:0])
            6'b000000: return "R2";
            6'b000011: return en ? "R3" : "R11";
            6'b000001: return en ? "R4" : "R11";
            6'b000010: return en ? "R5" : "R11";
            6'b000100: return (l > a) ? "R10" : "R6";
            6'b000111: return !en ? "R11" : (l > a) ? "R10" : "R7";
            6'b000101: return !en ? "R11" : (l > a + 32) ? "R10" : "R8";
            6'b000110: return !en ? "R11" : (l > a) ? "R10" : "R9";
            default:   return "R12";
        endcase
    endfunction

    // returns {wr_en, resv, result}
    function automatic logic [65:0] model(input logic [31:0] ins, input logic [63:0] rs,
                                          input logic [63:0] rt, input logic en);
        logic [63:0] src;
        logic [63:0] r;
        int a = int'(ins[15:11]);
        int l = int'(ins[10:6]);
        int lo = 0;
        int hi = 0;
        bit is_ext = 0;
        bit narrow = 0;
        bit wide = 1;
        if (ins[31:26] != 6'b011111) return '0;
        case (ins[5:0])
            6'b000000: begin is_ext = 1; narrow = 1; wide = 0; lo = l; hi = l + a; end
            6'b000011: begin is_ext = 1; lo = l; hi = l + a; end
            6'b000001: begin is_ext = 1; lo = l; hi = l + a + 32; end
            6'b000010: begin is_ext = 1; lo = l + 32; hi = l + a + 32; end
            6'b000100: begin narrow = 1; wide = 0; lo = l; hi = a; end
            6'b000111: begin lo = l; hi = a; end
            6'b000101: begin lo = l; hi = a + 32; end
            6'b000110: begin lo = l + 32; hi = a + 32; end
            default:   return {1'b0, 1'b1, 64'd0};
        endcase
        if (wide && !en) return {1'b0, 1'b1, 64'd0};
        if (is_ext) begin
            src = narrow ? {32'd0, rs[31:0]} : rs;
            r = '0;
            for (int i = 0; i <= hi - lo; i++)
                if (lo + i < 64) r[i] = src[lo + i];
        end else begin
            if (lo > hi) return {1'b1, 1'b0, rt};
            r = rt;
            for (int p = lo; p <= hi; p++) r[p] = rs[p - lo];
        end
        if (narrow) r = {{32{r[31]}}, r[31:0]};
        return {1'b1, 1'b0, r};
    endfunction

    task automatic compare(input string tag, input logic [65:0] exp);
        n_checks++;
        if ({wr_en_o, resv_o, result_o} !== exp) begin
            n_fails++;
            $display("FAIL %s: got we=%0b ri=%0b res=%h, expected we=%0b ri=%0b res=%h",
                     tag, wr_en_o, resv_o, result_o, exp[65], exp[64], exp[63:0]);
        end
    endtask

    task automatic run_vec(input logic [31:0] ins, input logic [63:0] rs,
                           input logic [63:0] rt, input logic en);
        instr_i = ins; rs_val_i = rs; rt_val_i = rt; en64_i = en;
        @(negedge clk);
        compare(req_tag(ins, en), model(ins, rs, rt, en));
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [63:0] pat_a = 64'h0123_4567_89AB_CDEF;
        logic [63:0] pat_b = 64'hFEDC_BA98_7654_3210;
        logic [5:0]  fns [8] = '{6'b000000, 6'b000100, 6'b000011, 6'b000001,
                                 6'b000010, 6'b000111, 6'b000101, 6'b000110};
        seed = $urandom(32'd24681);

        // R1: reset holds outputs at zero despite live inputs
        instr_i = mk(6'b000111, 20, 4); rs_val_i = pat_a; rt_val_i = pat_b;
        repeat (3) @(negedge clk);
        compare("R1", '0);
        rst_n = 1'b1;

        // directed corners
        run_vec(mk(6'b000000, 31, 0),  pat_b, pat_a, 1);   // R2 full width, sign from bit 31
        run_vec(mk(6'b000000, 20, 16), pat_b, pat_a, 1);   // R2 field crosses bit 31
        run_vec(mk(6'b000011, 31, 31), pat_b, pat_a, 1);   // R3 bits up to 62
        run_vec(mk(6'b000001, 31, 0),  pat_b, pat_a, 1);   // R4 full 64-bit field
        run_vec(mk(6'b000001, 31, 31), pat_b, pat_a, 1);   // R4 runs past bit 63
        run_vec(mk(6'b000010, 31, 31), pat_b, pat_a, 1);   // R5 runs past bit 63
        run_vec(mk(6'b000010, 0, 0),   pat_b, pat_a, 1);   // R5 single bit 32
        run_vec(mk(6'b000100, 31, 0),  pat_b, pat_a, 1);   // R6 full word
        run_vec(mk(6'b000100, 27, 8),  pat_b, pat_a, 1);   // R6
        run_vec(mk(6'b000111, 40 % 32, 3), pat_b, pat_a, 1); // R7
        run_vec(mk(6'b000101, 31, 0),  pat_b, pat_a, 1);   // R8 whole register
        run_vec(mk(6'b000110, 31, 31), pat_b, pat_a, 1);   // R9 top bit only
        run_vec(mk(6'b000100, 3, 9),   pat_b, pat_a, 1);   // R10 narrow, no sign extension
        run_vec(mk(6'b000111, 0, 31),  pat_b, pat_a, 1);   // R10
        run_vec(mk(6'b000110, 5, 6),   pat_b, pat_a, 1);   // R10
        run_vec(mk(6'b000011, 7, 2),   pat_b, pat_a, 0);   // R11
        run_vec(mk(6'b000101, 7, 2),   pat_b, pat_a, 0);   // R11
        run_vec(mk(6'b000000, 7, 2),   pat_b, pat_a, 0);   // R2 narrow unaffected by flag
        run_vec(mk(6'b111011, 7, 2),   pat_b, pat_a, 1);   // R12 unknown function
        run_vec({6'b011110, mk(6'b000000, 7, 2)}[31:0] & 32'h07FF_FFFF | 32'h7800_0000,
                pat_b, pat_a, 1);                          // R12 foreign major opcode

        // R13: outputs hold between edges
        run_vec(mk(6'b000011, 15, 4), pat_a, pat_b, 1);
        instr_i = mk(6'b000111, 15, 4);
        #1ns;
        compare("R13", model(mk(6'b000011, 15, 4), pat_a, pat_b, 1));
        @(negedge clk);
        compare("R13", model(instr_i, rs_val_i, rt_val_i, 1));

        // constrained random
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] ins;
            logic [63:0] rs;
            logic [63:0] rt;
            logic        en;
            ins = $urandom();
            rs  = {$urandom(), $urandom()};
            rt  = {$urandom(), $urandom()};
            en  = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 7) != 0) ins[31:26] = 6'b011111;
            if ($urandom_range(0, 7) != 0) ins[5:0] = fns[$urandom_range(0, 7)];
            run_vec(ins, rs, rt, en);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule